// File: doc/BRIEF.md
# Periodic Event Scheduler with Idle Detection

This block paces the background work of a stepped execution engine. Each pulse on `step` marks one completed unit of execution. A free-running counter advances on that pulse. The block compares the low bits of the counter with four power-of-two periods and issues four one-cycle strobes:

- a housekeeping tick;
- an I/O poll strobe;
- a vertical-retrace request;
- a display-refresh request.

The three slower strobes are nested inside the housekeeping tick. They can only fire on a step that also produces that tick.

At every I/O poll the block updates an idle counter. The counter is cleared when the poll sees serial or keyboard activity, or when either input queue still holds data. When both paths are quiet, the counter increments. It saturates at its maximum value.

Once the idle counter reaches a threshold, the block raises a sleep-permit level. The surrounding system may then wait for a long time instead of polling. The level is held low whenever the cursor is invisible, so a blinking cursor is never frozen in its dark phase. How and for how long the system sleeps is decided outside this block.

Top module: `step_event_sched`

## Requirements
- R1: After reset the step counter is zero, the idle counter is zero, all four strobes are low and `sleep_ok` is low.
- R2: The counter advances only on a cycle with `step` high. No strobe is ever high in a cycle that does not directly follow a `step` cycle.
- R3: `tick_hk` pulses for exactly one cycle, in the cycle after the step that brings the counter to a value whose low HK_BITS bits are all zero. With the default HK_BITS = 4 this is once every 16 steps.
- R4: `poll_stb` pulses in the cycle after the step that brings the counter to a value whose low POLL_BITS bits are zero. With the default POLL_BITS = 12 this is every 4096 steps. It is always accompanied by `tick_hk`.
- R5: `vretrace_req` pulses alongside `tick_hk` when the low VR_BITS bits of the new count are zero. The default VR_BITS is 9.
- R6: `refresh_req` pulses alongside `tick_hk` when the low DISP_BITS bits of the new count are zero. The default DISP_BITS is 14.
- R7: On a poll step with `ser_act` or `kbd_act` high, the idle counter clears to zero.
- R8: On a poll step with `ser_pending` or `kbd_pending` high, the idle counter clears to zero.
- R9: On a poll step with all four activity and queue inputs low, the idle counter increments. Those inputs have no effect on steps that are not polls.
- R10: `sleep_ok` is high exactly when the idle counter is at least IDLE_THRESH (default 10) and `cursor_on` is high. The cursor dependence is combinational.
- R11: While `cursor_on` is low, `sleep_ok` is low, whatever the idle count.
- R12: The idle counter saturates at 2^IDLE_W - 1 instead of wrapping, so `sleep_ok` stays high through any number of further idle polls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One execution step completed |
| ser_act | input | 1 | Serial input activity seen at this poll |
| kbd_act | input | 1 | Keyboard input activity seen at this poll |
| ser_pending | input | 1 | Serial receive queue is not empty |
| kbd_pending | input | 1 | Keyboard queue is not empty |
| cursor_on | input | 1 | Cursor currently visible |
| tick_hk | output | 1 | Housekeeping tick strobe |
| poll_stb | output | 1 | I/O poll strobe |
| vretrace_req | output | 1 | Vertical-retrace request strobe |
| refresh_req | output | 1 | Display-refresh request strobe |
| sleep_ok | output | 1 | Long wait permitted |

## Verification
Several functions can land on the same step.

The step that wraps the display period also completes a poll period. On that step the poll strobe, the idle-counter update, the retrace request and the refresh request all fire together with the housekeeping tick. The bench uses reduced periods so that this coincidence recurs often, and it compares every step against a model based only on the step count.

Activity is also applied exactly on a poll step and on neighbouring non-poll steps. The bench judges the result by whether `sleep_ok` rises after the expected number of quiet polls.

// File: rtl/step_event_sched.sv
module step_event_sched #(
  parameter int CNT_W       = 16,
  parameter int HK_BITS     = 4,
  parameter int VR_BITS     = 9,
  parameter int POLL_BITS   = 12,
  parameter int DISP_BITS   = 14,
  parameter int IDLE_W      = 4,
  parameter int IDLE_THRESH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic ser_act,
  input  logic kbd_act,
  input  logic ser_pending,
  input  logic kbd_pending,
  input  logic cursor_on,
  output logic tick_hk,
  output logic poll_stb,
  output logic vretrace_req,
  output logic refresh_req,
  output logic sleep_ok
);

  localparam logic [CNT_W-1:0]  ONE       = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  HK_MASK   = (ONE << HK_BITS) - ONE;
  localparam logic [CNT_W-1:0]  VR_MASK   = (ONE << VR_BITS) - ONE;
  localparam logic [CNT_W-1:0]  POLL_MASK = (ONE << POLL_BITS) - ONE;
  localparam logic [CNT_W-1:0]  DISP_MASK = (ONE << DISP_BITS) - ONE;
  localparam logic [IDLE_W-1:0] IDLE_MAX  = {IDLE_W{1'b1}};
  localparam logic [IDLE_W-1:0] IDLE_LIM  = IDLE_W'(IDLE_THRESH);

  logic [CNT_W-1:0]  step_cnt;
  logic [CNT_W-1:0]  cnt_nx;
  logic [IDLE_W-1:0] idle_q;
  logic              hk_hit, poll_hit, vr_hit, disp_hit, busy;

  assign cnt_nx   = step_cnt + ONE;
  assign hk_hit   = step && ((cnt_nx & HK_MASK) == '0);
  assign poll_hit = hk_hit && ((cnt_nx & POLL_MASK) == '0);
  assign vr_hit   = hk_hit && ((cnt_nx & VR_MASK) == '0);
  assign disp_hit = hk_hit && ((cnt_nx & DISP_MASK) == '0);
  assign busy     = ser_act || kbd_act || ser_pending || kbd_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_cnt     <= '0;
      tick_hk      <= 1'b0;
      poll_stb     <= 1'b0;
      vretrace_req <= 1'b0;
      refresh_req  <= 1'b0;
    end else begin
      if (step) step_cnt <= cnt_nx;
      tick_hk      <= hk_hit;
      poll_stb     <= poll_hit;
      vretrace_req <= vr_hit;
      refresh_req  <= disp_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      idle_q <= '0;
    else if (poll_hit) begin
      if (busy)
        idle_q <= '0;
      else if (idle_q != IDLE_MAX)
        idle_q <= idle_q + 1'b1;
    end
  end

  assign sleep_ok = (idle_q >= IDLE_LIM) && cursor_on;

  p_strobe_after_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_hk || poll_stb || vretrace_req || refresh_req) |-> $past(step));

  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_hk |=> !tick_hk);

  p_poll_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_stb |-> tick_hk);

  p_vr_nested_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vretrace_req |-> tick_hk);

  p_disp_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> tick_hk);

  p_busy_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_hit && busy) |=> (idle_q == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_hit |=> $stable(idle_q));

  p_sleep_cursor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ok |-> cursor_on);

  p_idle_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((idle_q == IDLE_MAX) && !(poll_hit && busy)) |=> (idle_q == IDLE_MAX));

endmodule

// File: tb/step_event_sched_bench.sv
module step_event_sched_bench;
  localparam int HKB = 2, VRB = 3, PLB = 5, DPB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic ser_act = 1'b0, kbd_act = 1'b0, ser_pending = 1'b0, kbd_pending = 1'b0;
  logic cursor_on = 1'b1;
  logic tick_hk, poll_stb, vretrace_req, refresh_req, sleep_ok;

  int n_chk = 0, n_fail = 0;
  int k = 0;
  int exp_idle = 0;

  always #5 clk = ~clk;

  step_event_sched #(.CNT_W(8), .HK_BITS(HKB), .VR_BITS(VRB), .POLL_BITS(PLB),
                     .DISP_BITS(DPB), .IDLE_W(4), .IDLE_THRESH(10)) u_step_event_sched (
    .clk(clk), .rst_n(rst_n), .step(step), .ser_act(ser_act), .kbd_act(kbd_act),
    .ser_pending(ser_pending), .kbd_pending(kbd_pending), .cursor_on(cursor_on),
    .tick_hk(tick_hk), .poll_stb(poll_stb), .vretrace_req(vretrace_req),
    .refresh_req(refresh_req), .sleep_ok(sleep_ok));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b (step %0d)", req, act, exp, k);
    end
  endtask

  function automatic logic exp_sleep();
    return (exp_idle >= 10) && cursor_on;
  endfunction

  task automatic step_once();
    logic is_poll;
    @(negedge clk);
    step = 1'b1;
    k++;
    is_poll = (k % (1 << PLB)) == 0;
    if (is_poll) begin
      if (ser_act || kbd_act || ser_pending || kbd_pending) exp_idle = 0;
      else if (exp_idle < 15) exp_idle++;
    end
    @(negedge clk);
    step = 1'b0;
    chk("R3 tick", tick_hk, (k % (1 << HKB)) == 0);
    chk("R4 poll", poll_stb, is_poll);
    chk("R5 vretrace", vretrace_req, (k % (1 << VRB)) == 0);
    chk("R6 refresh", refresh_req, (k % (1 << DPB)) == 0);
    chk("R10 sleep", sleep_ok, exp_sleep());
    @(negedge clk);
    chk("R3 single cycle", tick_hk, 1'b0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step_once();
  endtask

  task automatic run_to_poll();
    while (((k + 1) % (1 << PLB)) != 0) step_once();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = 0; exp_idle = 0;
    @(negedge clk);
    chk("R1 tick", tick_hk, 1'b0);
    chk("R1 poll", poll_stb, 1'b0);
    chk("R1 vretrace", vretrace_req, 1'b0);
    chk("R1 refresh", refresh_req, 1'b0);
    chk("R1 sleep", sleep_ok, 1'b0);
  endtask

  task automatic t_no_step_r2();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      chk("R2 idle tick", tick_hk | poll_stb | vretrace_req | refresh_req, 1'b0);
    end
    steps(1 << HKB);
  endtask

  task automatic t_strobes_r3_r6();
    steps(3 << DPB);
  endtask

  task automatic t_activity_r7();
    run_to_poll();
    ser_act = 1'b1; step_once(); ser_act = 1'b0;
    chk("R7 cleared by ser_act", sleep_ok, 1'b0);
    steps(10 << PLB);
    run_to_poll();
    kbd_act = 1'b1; step_once(); kbd_act = 1'b0;
    chk("R7 cleared by kbd_act", sleep_ok, 1'b0);
  endtask

  task automatic t_pending_r8();
    steps(12 << PLB);
    run_to_poll();
    kbd_pending = 1'b1; step_once(); kbd_pending = 1'b0;
    chk("R8 cleared by kbd_pending", sleep_ok, 1'b0);
    steps(12 << PLB);
    run_to_poll();
    ser_pending = 1'b1; step_once(); ser_pending = 1'b0;
    chk("R8 cleared by ser_pending", sleep_ok, 1'b0);
  endtask

  task automatic t_ignored_r9();
    for (int p = 0; p < 12; p++) begin
      ser_act = 1'b1; kbd_pending = 1'b1;
      while (((k + 1) % (1 << PLB)) != 0) step_once();
      ser_act = 1'b0; kbd_pending = 1'b0;
      step_once();
    end
    chk("R9 off-poll activity ignored", sleep_ok, 1'b1);
  endtask

  task automatic t_threshold_r10();
    run_to_poll();
    ser_act = 1'b1; step_once(); ser_act = 1'b0;
    for (int p = 0; p < 9; p++) begin run_to_poll(); step_once(); end
    chk("R10 below threshold", sleep_ok, 1'b0);
    run_to_poll(); step_once();
    chk("R10 at threshold", sleep_ok, 1'b1);
  endtask

  task automatic t_cursor_r11();
    @(negedge clk);
    cursor_on = 1'b0;
    #1 chk("R11 cursor off", sleep_ok, 1'b0);
    steps(2 << PLB);
    chk("R11 cursor off after polls", sleep_ok, 1'b0);
    cursor_on = 1'b1;
    #1 chk("R11 cursor back on", sleep_ok, 1'b1);
  endtask

  task automatic t_saturate_r12();
    steps(20 << PLB);
    chk("R12 saturated", sleep_ok, 1'b1);
    run_to_poll(); step_once();
    chk("R12 still high", sleep_ok, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_no_step_r2();
    t_strobes_r3_r6();
    t_activity_r7();
    t_pending_r8();
    t_ignored_r9();
    t_threshold_r10();
    t_cursor_r11();
    t_saturate_r12();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule